// File: doc/BRIEF.md
# Polled Cell Source for a Shared Receive Cell Bus

This block is the PHY-side end of an 8-bit multi-PHY cell bus in the receive direction. It is the side that hands cells to the layer above. It stores whole 53-byte cells that arrive on a local load port. A bus master shares one address bus, one active-low enable and one data bus among several PHYs. The master polls each PHY by address. When the polled address is this PHY's own, the block answers with a cell-available flag.

After the master selects the PHY and asserts enable, the block sends the stored cell one byte per clock. It marks the first byte with a start-of-cell flag. The data and start-of-cell outputs have a drive-enable that models tri-stating on the shared bus. If the master moves to another PHY part-way through a cell, the block keeps its place in the cell and resumes from that byte the next time it is selected.

Transfer control is a five-state machine:
- `ST_IDLE`: not selected.
- `ST_ARMED`: selected, with nothing on the bus.
- `ST_SEND`: a byte was loaded on the last edge.
- `ST_STALL`: still selected and driving, but enable was deasserted, so the last byte is held.
- `ST_PARK`: another address was selected while this PHY drove the bus. The bus stays driven for one more clock.

The transitions are:
- `ST_IDLE` to `ST_ARMED`: the own address is seen with enable deasserted.
- `ST_ARMED` to `ST_IDLE`: the address moves elsewhere with enable deasserted.
- `ST_ARMED` to `ST_SEND`: enable is seen with a complete cell stored.
- `ST_SEND` or `ST_STALL` to `ST_SEND`: enable is seen and a complete cell remains.
- `ST_SEND` or `ST_STALL` to `ST_ARMED`: enable is seen but no complete cell remains.
- `ST_SEND` to `ST_STALL`: enable is deasserted while the own address is present.
- `ST_SEND` or `ST_STALL` to `ST_PARK`: enable is deasserted while another address is present.
- `ST_PARK` to `ST_ARMED` or `ST_IDLE`, on the next clock.

Top module: `phy_cell_responder`

## Requirements
- R1: The clock edge that samples `bus_addr` equal to `my_addr` sets `clav_drive` high, and it is visible one clock later. When the sampled address is any other value, `clav_drive` is low one clock later.
- R2: `clav` is high only when `clav_drive` is high and at least one complete 53-byte cell is stored. The cell currently being sent still counts until its last byte has gone out.
- R3: The PHY becomes selected on an edge that samples `bus_addr == my_addr` with `bus_en_n` high. On a later edge that samples `bus_en_n` low, if a complete cell is stored, the next byte appears on `rx_data` with `rx_drive` high. The address bus may hold any value during that edge.
- R4: `rx_soc` is high exactly while the byte at position 0 of a cell is on the bus.
- R5: Cell bytes come out in the order they were loaded, one byte per edge on which enable is sampled low. `rx_soc` is low on every byte after the first.
- R6: Suppose the PHY is driving the bus and an edge samples `bus_en_n` high with another address. The PHY keeps driving for one more clock and releases `rx_drive` on the following edge. While `rx_drive` is low, `rx_data` and `rx_soc` read 0.
- R7: Address 5'h1F is the null address. With `my_addr` set to 5'h1F the block never raises `clav_drive` and is never selected.
- R8: Deselection or a pause in the middle of a cell does not lose the byte position. An edge that samples `bus_en_n` high while the own address is present holds the current byte on the bus. After reselection the byte following the last one sent comes out, with `rx_soc` low.
- R9: A cell leaves storage only after its 53rd byte has been sent. If another complete cell is stored, its first byte follows on the next enabled edge with `rx_soc` high.
- R10: A byte on `ld_data` is stored on every edge where `ld_valid` and `ld_ready` are both high. Every 53 stored bytes form one complete cell. `ld_ready` is low exactly when all `CELLS*53` byte slots are occupied.
- R11: While `rst_n` is low, `rx_drive`, `rx_soc`, `rx_data`, `clav` and `clav_drive` are all 0, and storage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | 5 | This PHY's bus address (5'h1F disables it) |
| bus_addr | input | 5 | Shared poll/select address from the master |
| bus_en_n | input | 1 | Shared active-low read enable from the master |
| rx_data | output | 8 | Cell byte, 0 when not driven |
| rx_soc | output | 1 | Start-of-cell flag, 0 when not driven |
| rx_drive | output | 1 | Drive-enable for `rx_data` and `rx_soc` |
| clav | output | 1 | Cell-available answer to a poll |
| clav_drive | output | 1 | Drive-enable for `clav` |
| ld_valid | input | 1 | Local load byte valid |
| ld_data | input | 8 | Local load byte |
| ld_ready | output | 1 | Storage can accept a byte |

## Verification
A wrong controller state shows at the ports within one clock:
- A machine stuck in `ST_PARK` or `ST_STALL` leaves `rx_drive` high after the master has moved on.
- A lost selection leaves the bus undriven on the first enabled edge.

A wrong byte position shows on the next byte sent. Either `rx_soc` appears off position 0, or `rx_data` departs from the loaded order, for example after a resume. A wrong cell count shows on the next poll, because `clav` disagrees with the stored cells. When storage fills, a wrong count also shows as an `ld_ready` edge at the wrong byte. A reference model in the bench compares every output on every clock, so the first divergent cycle is reported.

// File: rtl/utl2_pkg.sv
package utl2_pkg;
    localparam int CELL_LEN = 53;
    localparam logic [4:0] NULL_ADDR = 5'h1F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SEND,
        ST_STALL,
        ST_PARK
    } xfer_state_e;
endpackage

// File: rtl/cell_store.sv
module cell_store
    import utl2_pkg::*;
#(
    parameter int CELLS = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    output logic          ld_ready,
    input  logic          rd_take,
    input  logic          rd_cell_end,
    output logic [DW-1:0] rd_byte,
    output logic          have_cell
);
    localparam int DEPTH = CELLS * CELL_LEN;
    localparam int AW    = $clog2(DEPTH);
    localparam int UW    = $clog2(DEPTH + 1);
    localparam int CW    = $clog2(CELLS + 1);
    localparam int PW    = $clog2(CELL_LEN);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [UW-1:0] used;
    logic [CW-1:0] cells;
    logic [PW-1:0] wr_cnt;
    logic          accept, wr_cell_end;

    assign ld_ready    = used < UW'(DEPTH);
    assign accept      = ld_valid && ld_ready;
    assign wr_cell_end = accept && (wr_cnt == PW'(CELL_LEN - 1));
    assign rd_byte     = mem[rd_ptr];
    assign have_cell   = cells != '0;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
            cells  <= '0;
            wr_cnt <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                wr_cnt <= wr_cell_end ? '0 : wr_cnt + 1'b1;
            end
            if (rd_take) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (accept && !rd_take) begin
                used <= used + 1'b1;
            end else if (!accept && rd_take) begin
                used <= used - 1'b1;
            end
            if (wr_cell_end && !rd_cell_end) begin
                cells <= cells + 1'b1;
            end else if (!wr_cell_end && rd_cell_end) begin
                cells <= cells - 1'b1;
            end
        end
    end

    // R10: byte occupancy never exceeds the storage size
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (used == UW'(DEPTH)) |=> (used <= UW'(DEPTH)));

    // R9: a byte is only taken while a complete cell is stored
    p_take_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> have_cell);

    // R9: the cell count only drops on the edge that sends a 53rd byte
    p_pop_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cell_end |=> (cells >= $past(cells)));
endmodule

// File: rtl/poll_reply.sv
module poll_reply (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_hit,
    input  logic have_cell,
    output logic clav,
    output logic clav_drive
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clav       <= 1'b0;
            clav_drive <= 1'b0;
        end else begin
            clav_drive <= addr_hit;
            clav       <= addr_hit && have_cell;
        end
    end

    // R2: a cell-available answer is only given while the flag is driven
    p_clav_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clav |-> clav_drive);
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import utl2_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_hit,
    input  logic          enb,
    input  logic          have_cell,
    input  logic [DW-1:0] rd_byte,
    output logic          rd_take,
    output logic          rd_cell_end,
    output logic [DW-1:0] rx_data,
    output logic          rx_soc,
    output logic          rx_drive
);
    localparam int PW = $clog2(CELL_LEN);

    xfer_state_e   state, nxt;
    logic          load;
    logic [PW-1:0] pos;
    logic [DW-1:0] data_q;
    logic          soc_q;

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!enb && addr_hit) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (!enb) begin
                    nxt = addr_hit ? ST_ARMED : ST_IDLE;
                end else if (have_cell) begin
                    load = 1'b1;
                    nxt  = ST_SEND;
                end
            end
            ST_SEND, ST_STALL: begin
                if (enb) begin
                    if (have_cell) begin
                        load = 1'b1;
                        nxt  = ST_SEND;
                    end else begin
                        nxt = ST_ARMED;
                    end
                end else begin
                    nxt = addr_hit ? ST_STALL : ST_PARK;
                end
            end
            ST_PARK: begin
                nxt = (!enb && addr_hit) ? ST_ARMED : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign rd_take     = load;
    assign rd_cell_end = load && (pos == PW'(CELL_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            data_q <= '0;
            soc_q  <= 1'b0;
        end else if (load) begin
            data_q <= rd_byte;
            soc_q  <= (pos == '0);
            pos    <= rd_cell_end ? '0 : pos + 1'b1;
        end
    end

    always_comb begin
        rx_drive = (state == ST_SEND) || (state == ST_STALL) || (state == ST_PARK);
        rx_data  = rx_drive ? data_q : '0;
        rx_soc   = rx_drive && soc_q;
    end

    // R4: the start flag accompanies only the byte at position zero
    p_soc_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && pos == '0) |=> rx_soc);

    // R5: later bytes carry no start flag
    p_soc_later_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && pos != '0) |=> !rx_soc);

    // R6: a parked bus is released on the next edge
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK) |=> !rx_drive);

    // R8: a pause with the own address holds the byte on the bus
    p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !enb && addr_hit) |=> (rx_drive && $stable(rx_data)));

    // R3: selection needs the own address with enable deasserted
    p_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !addr_hit) |=> (state == ST_IDLE));
endmodule

// File: rtl/phy_cell_responder.sv
module phy_cell_responder
    import utl2_pkg::*;
#(
    parameter int CELLS = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    my_addr,
    input  logic [4:0]    bus_addr,
    input  logic          bus_en_n,
    output logic [DW-1:0] rx_data,
    output logic          rx_soc,
    output logic          rx_drive,
    output logic          clav,
    output logic          clav_drive,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    output logic          ld_ready
);
    logic          addr_hit;
    logic          have_cell;
    logic          rd_take, rd_cell_end;
    logic [DW-1:0] rd_byte;

    assign addr_hit = (bus_addr == my_addr) && (my_addr != NULL_ADDR);

    cell_store #(.CELLS(CELLS), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_data     (ld_data),
        .ld_ready    (ld_ready),
        .rd_take     (rd_take),
        .rd_cell_end (rd_cell_end),
        .rd_byte     (rd_byte),
        .have_cell   (have_cell)
    );

    poll_reply u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_hit   (addr_hit),
        .have_cell  (have_cell),
        .clav       (clav),
        .clav_drive (clav_drive)
    );

    xfer_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_hit    (addr_hit),
        .enb         (!bus_en_n),
        .have_cell   (have_cell),
        .rd_byte     (rd_byte),
        .rd_take     (rd_take),
        .rd_cell_end (rd_cell_end),
        .rx_data     (rx_data),
        .rx_soc      (rx_soc),
        .rx_drive    (rx_drive)
    );

    // R1: a poll of the own address is answered on the next clock
    p_poll_reply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == my_addr && my_addr != NULL_ADDR) |=> clav_drive);

    // R7: the null address never produces an answer
    p_null_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (my_addr == NULL_ADDR) |=> !clav_drive);
endmodule

// File: tb/test_phy_cell_responder.sv
module test_phy_cell_responder;
    localparam int DEPTH = 4 * 53;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] my_addr, bus_addr;
    logic       bus_en_n;
    logic [7:0] rx_data;
    logic       rx_soc, rx_drive, clav, clav_drive;
    logic       ld_valid;
    logic [7:0] ld_data;
    logic       ld_ready;

    always #10 clk = ~clk;

    phy_cell_responder i_phy_cell_responder (
        .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .bus_addr(bus_addr),
        .bus_en_n(bus_en_n), .rx_data(rx_data), .rx_soc(rx_soc),
        .rx_drive(rx_drive), .clav(clav), .clav_drive(clav_drive),
        .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // behavioural reference model
    logic [7:0] q[$];
    int   m_cells, m_wcnt, m_pos;
    bit   m_sel, m_drv, m_soc, m_clav, m_clavd;
    logic [7:0] m_data;
    bit   e_s, hit_s, have_s, rdy_s, nsel, ndrv;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_cells = 0; m_wcnt = 0; m_pos = 0;
            m_sel = 0; m_drv = 0; m_soc = 0; m_clav = 0; m_clavd = 0;
            m_data = '0;
        end else begin
            e_s    = !bus_en_n;
            hit_s  = (bus_addr == my_addr) && (my_addr != 5'h1F);
            have_s = m_cells > 0;
            rdy_s  = q.size() < DEPTH;
            m_clavd = hit_s;
            m_clav  = hit_s && have_s;
            if (m_sel && e_s && have_s) begin
                m_data = q.pop_front();
                m_soc  = (m_pos == 0);
                m_pos++;
                if (m_pos == 53) begin
                    m_pos = 0;
                    m_cells--;
                end
            end
            if (e_s) begin
                nsel = m_sel;
                ndrv = m_sel && have_s;
            end else begin
                nsel = hit_s;
                ndrv = m_drv && m_sel;
            end
            m_sel = nsel;
            m_drv = ndrv;
            if (ld_valid && rdy_s) begin
                q.push_back(ld_data);
                m_wcnt++;
                if (m_wcnt == 53) begin
                    m_wcnt = 0;
                    m_cells++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 clav_drive", int'(clav_drive), int'(m_clavd));
            chk("R2 clav", int'(clav), int'(m_clav));
            chk("R6 rx_drive", int'(rx_drive), int'(m_drv));
            chk("R5 rx_data", int'(rx_data), m_drv ? int'(m_data) : 0);
            chk("R4 rx_soc", int'(rx_soc), int'(m_drv && m_soc));
            chk("R10 ld_ready", int'(ld_ready), int'(q.size() < DEPTH));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    task automatic load_cell(input int id);
        for (int i = 0; i < 53; i++) begin
            ld_valid = 1'b1;
            ld_data  = 8'((id * 16) + i);
            @(negedge clk);
        end
        ld_valid = 1'b0;
    endtask

    initial begin
        int last;
        int soc_at;
        rst_n = 1'b0; my_addr = 5'h05; bus_addr = 5'h1F; bus_en_n = 1'b1;
        ld_valid = 1'b0; ld_data = '0;
        repeat (3) @(negedge clk);
        chk("R11 rx_drive", int'(rx_drive), 0);
        chk("R11 clav_drive", int'(clav_drive), 0);
        chk("R11 rx_data", int'(rx_data), 0);
        chk("R11 ld_ready", int'(ld_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        bus_addr = 5'h05; @(negedge clk);
        chk("R1 poll own", int'(clav_drive), 1);
        chk("R2 empty", int'(clav), 0);
        bus_addr = 5'h06; @(negedge clk);
        chk("R1 poll other", int'(clav_drive), 0);

        load_cell(1);
        load_cell(2);
        bus_addr = 5'h05; @(negedge clk);
        chk("R2 stored", int'(clav), 1);

        bus_en_n = 1'b0; bus_addr = 5'h1F; @(negedge clk);
        chk("R3 drive", int'(rx_drive), 1);
        chk("R4 first soc", int'(rx_soc), 1);
        chk("R3 first byte", int'(rx_data), 8'h10);
        @(negedge clk);
        chk("R5 second soc", int'(rx_soc), 0);
        chk("R5 second byte", int'(rx_data), 8'h11);
        repeat (18) @(negedge clk);
        last = int'(rx_data);

        bus_en_n = 1'b1; bus_addr = 5'h05; @(negedge clk);
        chk("R8 stall drive", int'(rx_drive), 1);
        chk("R8 stall hold", int'(rx_data), last);
        bus_en_n = 1'b0; bus_addr = 5'h1F; @(negedge clk);
        chk("R8 after stall", int'(rx_data), last + 1);
        last = last + 1;

        bus_en_n = 1'b1; bus_addr = 5'h06; @(negedge clk);
        chk("R6 park drive", int'(rx_drive), 1);
        bus_en_n = 1'b0; @(negedge clk);
        chk("R6 released", int'(rx_drive), 0);

        bus_en_n = 1'b1; bus_addr = 5'h05; @(negedge clk);
        chk("R3 armed quiet", int'(rx_drive), 0);
        bus_en_n = 1'b0; bus_addr = 5'h1F; @(negedge clk);
        chk("R8 resume byte", int'(rx_data), last + 1);
        chk("R8 resume soc", int'(rx_soc), 0);

        soc_at = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (rx_soc) begin
                soc_at = k;
                break;
            end
        end
        chk("R9 cell boundary", soc_at, 32);
        chk("R9 next cell first", int'(rx_data), 8'h20);

        bus_en_n = 1'b1; bus_addr = 5'h06; @(negedge clk);
        bus_en_n = 1'b0; @(negedge clk);
        bus_en_n = 1'b1;

        my_addr = 5'h1F; bus_addr = 5'h1F; @(negedge clk);
        @(negedge clk);
        chk("R7 null silent", int'(clav_drive), 0);
        chk("R7 null no drive", int'(rx_drive), 0);
        my_addr = 5'h05; bus_addr = 5'h06;

        for (int n = 0; n < 250; n++) begin
            ld_valid = 1'b1;
            ld_data  = 8'(n * 3);
            @(negedge clk);
        end
        ld_valid = 1'b0;
        chk("R10 full", int'(ld_ready), 0);

        bus_addr = 5'h05; @(negedge clk);
        chk("R2 full clav", int'(clav), 1);
        bus_en_n = 1'b0; bus_addr = 5'h1F;
        repeat (300) @(negedge clk);
        chk("R9 drained", int'(rx_drive), 0);
        chk("R10 space again", int'(ld_ready), 1);
        bus_en_n = 1'b1;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule